// File: doc/BRIEF.md
# Write-Through Snooping Invalidate Line Controller

This block keeps the coherence state of a small direct-mapped, write-through cache that sits on a bus shared with other caches. It holds one tag and a two-valued state (INVALID or VALID) for each line. It does not hold data. The local processor issues reads, writes and line replacements on one port. Each request gets a one-cycle-later response that says whether the line held a valid copy of the address. Every local write is forwarded to the bus one cycle later, so that main memory always holds the latest value.

A second port observes bus traffic from the other caches. A remote write whose index and tag match a VALID line removes the local copy. Remote reads and remote replacements leave the line alone. A local read or write always installs the addressed tag as VALID, even on a miss. When a snooped event and a local request fall on the same line in one cycle, the snooped event is applied first, and the local request sees the result.

Addresses are word addresses. The low `$clog2(NUM_LINES)` bits select the line and the remaining upper bits form the tag.

Top module: `wtsi_ctrl`

## Requirements
- R1: After reset every line is INVALID, so the first local read to any line reports a miss.
- R2: A local request (`cpu_op` 0 = read, 1 = write, 2 = replace, 3 = no-op) with `cpu_valid` high produces `rsp_valid` high in the next cycle. `rsp_hit` is high only when the addressed line was VALID with a matching tag. `rsp_valid` and `rsp_hit` are low in any cycle that follows no request.
- R3: A local read leaves the addressed line VALID holding the request's tag, whether it hit or missed.
- R4: A local write leaves the addressed line VALID holding the request's tag, even when it missed.
- R5: Each local write drives `bus_wr_valid` high in the next cycle for exactly one cycle, carrying the write's address and data. No other request raises `bus_wr_valid`.
- R6: A local replace clears the addressed line to INVALID whatever its stored tag, and `rsp_hit` reports whether the tag matched.
- R7: A snooped write (`snp_op` = 1, same encoding as `cpu_op`) whose index and tag match a VALID line makes that line INVALID.
- R8: A snooped read, a snooped replace, or a snooped write whose tag differs from the stored tag leaves the line's state and tag unchanged.
- R9: When a snooped event and a local request address the same line in one cycle, the snooped event is applied first. The local request's hit/miss and state update start from the post-snoop state.
- R10: Op code 3 on either port changes no line and raises no bus write. A local op code 3 still gets a response that reports hit or miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Local request present |
| cpu_op | input | 2 | Local operation: 0 read, 1 write, 2 replace, 3 no-op |
| cpu_addr | input | ADDR_W | Local word address |
| cpu_wdata | input | DATA_W | Local write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Addressed line was VALID with matching tag |
| snp_valid | input | 1 | Snooped bus event present |
| snp_op | input | 2 | Snooped operation, same encoding as cpu_op |
| snp_addr | input | ADDR_W | Snooped word address |
| bus_wr_valid | output | 1 | Write-through request to memory |
| bus_wr_addr | output | ADDR_W | Write-through address |
| bus_wr_data | output | DATA_W | Write-through data |

## Verification
The bench builds the controller with four lines, a six-bit address (four tag bits) and sixteen-bit data. Random addresses are drawn from a few tags over four indices, so local and snooped traffic collide on the same line and the same tag often. With this setup, same-cycle snoop-then-local ordering, tag-mismatch snoops and replacements of non-matching lines occur many times in the random phase. Directed steps first cover the reset miss, write allocation, remote invalidation, the remote events that have no effect, and op code 3.

// File: rtl/wtsi_pkg.sv
package wtsi_pkg;

    typedef enum logic [1:0] {
        OP_READ    = 2'd0,
        OP_WRITE   = 2'd1,
        OP_REPLACE = 2'd2,
        OP_NONE    = 2'd3
    } wtsi_op_e;

    typedef enum logic {
        LN_INVALID = 1'b0,
        LN_VALID   = 1'b1
    } wtsi_line_e;

    // Effect of a snooped bus event on one line (index already matched).
    function automatic wtsi_line_e snoop_next(input wtsi_line_e cur,
                                              input wtsi_op_e   op,
                                              input logic       tag_eq);
        wtsi_line_e nxt;
        nxt = cur;
        unique case (cur)
            LN_VALID: begin
                if (op == OP_WRITE && tag_eq) nxt = LN_INVALID;
                else                          nxt = LN_VALID;
            end
            LN_INVALID: nxt = LN_INVALID;
            default:    nxt = LN_INVALID;
        endcase
        return nxt;
    endfunction

    // Effect of a local processor request on one line (index matched).
    function automatic wtsi_line_e local_next(input wtsi_line_e cur,
                                              input wtsi_op_e   op);
        wtsi_line_e nxt;
        nxt = cur;
        unique case (op)
            OP_READ:    nxt = LN_VALID;
            OP_WRITE:   nxt = LN_VALID;
            OP_REPLACE: nxt = LN_INVALID;
            OP_NONE:    nxt = cur;
            default:    nxt = cur;
        endcase
        return nxt;
    endfunction

    // Whether a local request installs its tag into the line.
    function automatic logic local_installs(input wtsi_op_e op);
        return (op == OP_READ) || (op == OP_WRITE);
    endfunction

endpackage

// File: rtl/wtsi_index_dec.sv
module wtsi_index_dec #(
    parameter int NUM_LINES = 16,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                 en,
    input  logic [IDX_W-1:0]     idx,
    output logic [NUM_LINES-1:0] sel
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_sel
        assign sel[g] = en && (idx == IDX_W'(g));
    end

endmodule

// File: rtl/wtsi_line.sv
module wtsi_line
    import wtsi_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snp_sel,
    input  wtsi_op_e         snp_op,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic             loc_sel,
    input  wtsi_op_e         loc_op,
    input  logic [TAG_W-1:0] loc_tag,
    output logic             loc_hit
);

    wtsi_line_e       st_q;
    wtsi_line_e       st_mid;
    wtsi_line_e       st_d;
    logic [TAG_W-1:0] tag_q;
    logic [TAG_W-1:0] tag_d;

    // State register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= LN_INVALID;
            tag_q <= '0;
        end else begin
            st_q  <= st_d;
            tag_q <= tag_d;
        end
    end

    // Next-state and output process: snoop first, local second.
    always_comb begin
        st_mid = st_q;
        if (snp_sel) begin
            st_mid = snoop_next(st_q, snp_op, tag_q == snp_tag);
        end

        loc_hit = (st_mid == LN_VALID) && (tag_q == loc_tag);

        st_d  = st_mid;
        tag_d = tag_q;
        if (loc_sel) begin
            st_d = local_next(st_mid, loc_op);
            if (local_installs(loc_op)) begin
                tag_d = loc_tag;
            end
        end
    end

endmodule

// File: rtl/wtsi_resp.sv
module wtsi_resp #(
    parameter int NUM_LINES = 16,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic [IDX_W-1:0]     idx,
    input  logic [NUM_LINES-1:0] hit_vec,
    output logic                 rsp_valid,
    output logic                 rsp_hit
);

    logic hit_d;

    always_comb begin
        hit_d = req && hit_vec[idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
        end else begin
            rsp_valid <= req;
            rsp_hit   <= hit_d;
        end
    end

endmodule

// File: rtl/wtsi_wt_port.sv
module wtsi_wt_port
    import wtsi_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  wtsi_op_e          op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              bus_wr_valid,
    output logic [ADDR_W-1:0] bus_wr_addr,
    output logic [DATA_W-1:0] bus_wr_data
);

    logic fire;

    always_comb begin
        fire = req && (op == OP_WRITE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_wr_valid <= 1'b0;
            bus_wr_addr  <= '0;
            bus_wr_data  <= '0;
        end else begin
            bus_wr_valid <= fire;
            if (fire) begin
                bus_wr_addr <= addr;
                bus_wr_data <= wdata;
            end
        end
    end

endmodule

// File: rtl/wtsi_ctrl.sv
module wtsi_ctrl
    import wtsi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int TAG_W    = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic [1:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              bus_wr_valid,
    output logic [ADDR_W-1:0] bus_wr_addr,
    output logic [DATA_W-1:0] bus_wr_data
);

    wtsi_op_e             loc_op;
    wtsi_op_e             snp_op_e;
    logic [IDX_W-1:0]     loc_idx;
    logic [TAG_W-1:0]     loc_tag;
    logic [IDX_W-1:0]     snp_idx;
    logic [TAG_W-1:0]     snp_tag;
    logic [NUM_LINES-1:0] loc_sel;
    logic [NUM_LINES-1:0] snp_sel;
    logic [NUM_LINES-1:0] hit_vec;

    assign loc_op   = wtsi_op_e'(cpu_op);
    assign snp_op_e = wtsi_op_e'(snp_op);
    assign loc_idx  = cpu_addr[IDX_W-1:0];
    assign loc_tag  = cpu_addr[ADDR_W-1:IDX_W];
    assign snp_idx  = snp_addr[IDX_W-1:0];
    assign snp_tag  = snp_addr[ADDR_W-1:IDX_W];

    wtsi_index_dec #(.NUM_LINES(NUM_LINES)) u_loc_dec (
        .en  (cpu_valid),
        .idx (loc_idx),
        .sel (loc_sel)
    );

    wtsi_index_dec #(.NUM_LINES(NUM_LINES)) u_snp_dec (
        .en  (snp_valid),
        .idx (snp_idx),
        .sel (snp_sel)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        wtsi_line #(.TAG_W(TAG_W)) u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .snp_sel (snp_sel[g]),
            .snp_op  (snp_op_e),
            .snp_tag (snp_tag),
            .loc_sel (loc_sel[g]),
            .loc_op  (loc_op),
            .loc_tag (loc_tag),
            .loc_hit (hit_vec[g])
        );
    end

    wtsi_resp #(.NUM_LINES(NUM_LINES)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (cpu_valid),
        .idx       (loc_idx),
        .hit_vec   (hit_vec),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit)
    );

    wtsi_wt_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wt (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (cpu_valid),
        .op           (loc_op),
        .addr         (cpu_addr),
        .wdata        (cpu_wdata),
        .bus_wr_valid (bus_wr_valid),
        .bus_wr_addr  (bus_wr_addr),
        .bus_wr_data  (bus_wr_data)
    );

endmodule

// File: rtl/wtsi_ctrl_chk.sv
module wtsi_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic [1:0]        cpu_op,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              snp_valid,
    input logic [1:0]        snp_op,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              bus_wr_valid,
    input logic [ADDR_W-1:0] bus_wr_addr,
    input logic [DATA_W-1:0] bus_wr_data
);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid |=> rsp_valid);  // R2

    AST_HIT_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);  // R2

    AST_WRITE_REACHES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_op == 2'd1) |=>
            (bus_wr_valid && bus_wr_addr == $past(cpu_addr) && bus_wr_data == $past(cpu_wdata)));  // R5

    AST_BUS_ONLY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_valid |-> $past(cpu_valid && cpu_op == 2'd1));  // R5

    AST_WRITE_THEN_READ_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_op == 2'd1) ##1
        (cpu_valid && cpu_op == 2'd0 && cpu_addr == $past(cpu_addr) && !snp_valid)
        |=> rsp_hit);  // R4

    AST_REPLACE_THEN_READ_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_op == 2'd2) ##1
        (cpu_valid && cpu_op == 2'd0 && cpu_addr == $past(cpu_addr))
        |=> !rsp_hit);  // R6

    AST_SNOOP_WRITE_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_op == 2'd1 && cpu_valid && cpu_op == 2'd0 && cpu_addr == snp_addr)
        |=> !rsp_hit);  // R9

endmodule

bind wtsi_ctrl wtsi_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_valid    (cpu_valid),
    .cpu_op       (cpu_op),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .snp_valid    (snp_valid),
    .snp_op       (snp_op),
    .snp_addr     (snp_addr),
    .bus_wr_valid (bus_wr_valid),
    .bus_wr_addr  (bus_wr_addr),
    .bus_wr_data  (bus_wr_data)
);

// File: tb/wtsi_ctrl_tb.sv
module wtsi_ctrl_tb;

    localparam int NL    = 4;
    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int IW    = 2;
    localparam int TW    = AW - IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_valid = 1'b0;
    logic [1:0]    cpu_op = 2'd0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          rsp_valid;
    logic          rsp_hit;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_op = 2'd0;
    logic [AW-1:0] snp_addr = '0;
    logic          bus_wr_valid;
    logic [AW-1:0] bus_wr_addr;
    logic [DW-1:0] bus_wr_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic          m_val [NL];
    logic [TW-1:0] m_tag [NL];

    always #10 clk = ~clk;

    wtsi_ctrl #(.NUM_LINES(NL), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk, .rst_n, .cpu_valid, .cpu_op, .cpu_addr, .cpu_wdata,
        .rsp_valid, .rsp_hit, .snp_valid, .snp_op, .snp_addr,
        .bus_wr_valid, .bus_wr_addr, .bus_wr_data
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic model_hit(input logic [AW-1:0] a);
        return m_val[a[IW-1:0]] && (m_tag[a[IW-1:0]] == a[AW-1:IW]);
    endfunction

    // One cycle: drive at negedge, update model (snoop first), check after edge.
    task automatic step(input bit v, input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input bit sv, input logic [1:0] sop,
                        input logic [AW-1:0] sa, input string req);
        logic exp_hit;
        cpu_valid = v; cpu_op = op; cpu_addr = a; cpu_wdata = d;
        snp_valid = sv; snp_op = sop; snp_addr = sa;
        if (sv && sop == 2'd1 && model_hit(sa)) m_val[sa[IW-1:0]] = 1'b0;
        exp_hit = v && model_hit(a);
        if (v && (op == 2'd0 || op == 2'd1)) begin
            m_val[a[IW-1:0]] = 1'b1;
            m_tag[a[IW-1:0]] = a[AW-1:IW];
        end else if (v && op == 2'd2) begin
            m_val[a[IW-1:0]] = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        cpu_valid = 1'b0; snp_valid = 1'b0;
        chk(rsp_valid == v, req, "rsp_valid", rsp_valid, v);
        chk(rsp_hit == exp_hit, req, "rsp_hit", rsp_hit, exp_hit);
        chk(bus_wr_valid == (v && op == 2'd1), "R5", "bus_wr_valid", bus_wr_valid, v && op == 2'd1);
        if (v && op == 2'd1) begin
            chk(bus_wr_addr == a, "R5", "bus_wr_addr", bus_wr_addr, a);
            chk(bus_wr_data == d, "R5", "bus_wr_data", bus_wr_data, d);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, input string req);
        step(1'b1, 2'd0, a, '0, 1'b0, 2'd0, '0, req);
    endtask

    task automatic snoop(input logic [1:0] sop, input logic [AW-1:0] sa, input string req);
        step(1'b0, 2'd0, '0, '0, 1'b1, sop, sa, req);
    endtask

    initial begin
        for (int i = 0; i < NL; i++) begin
            m_val[i] = 1'b0;
            m_tag[i] = '0;
        end
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: fresh lines miss (reads also allocate, R3)
        for (int i = 0; i < NL; i++) rd(AW'(i), "R1");
        rd(6'h00, "R3");
        rd(6'h14, "R3");                         // idx0 tag5: miss, reallocates
        rd(6'h00, "R3");                         // old tag now misses
        // R4: write miss allocates, then hits
        step(1'b1, 2'd1, 6'h09, 16'hbeef, 1'b0, 2'd0, '0, "R4");
        rd(6'h09, "R4");
        step(1'b1, 2'd1, 6'h09, 16'h1234, 1'b0, 2'd0, '0, "R5");
        // R6: replace with non-matching tag still clears
        step(1'b1, 2'd2, 6'h3c, '0, 1'b0, 2'd0, '0, "R6");
        rd(6'h00, "R6");
        step(1'b1, 2'd2, 6'h00, '0, 1'b0, 2'd0, '0, "R6");
        // R8: remote read, replace, other-tag write leave line
        snoop(2'd0, 6'h09, "R8");
        snoop(2'd2, 6'h09, "R8");
        snoop(2'd1, 6'h0d, "R8");
        rd(6'h09, "R8");
        // R7: matching remote write invalidates
        snoop(2'd1, 6'h09, "R7");
        rd(6'h09, "R7");
        // R9: same cycle snoop write + local read on same line
        rd(6'h06, "R9");
        step(1'b1, 2'd0, 6'h06, '0, 1'b1, 2'd1, 6'h06, "R9");
        rd(6'h06, "R9");
        // R9: snoop write + local write same line, write reinstalls
        step(1'b1, 2'd1, 6'h06, 16'h0a0a, 1'b1, 2'd1, 6'h06, "R9");
        rd(6'h06, "R9");
        // R10: op code 3 on both ports
        step(1'b1, 2'd3, 6'h06, 16'hffff, 1'b1, 2'd3, 6'h06, "R10");
        rd(6'h06, "R10");
        step(1'b1, 2'd3, 6'h0b, '0, 1'b0, 2'd0, '0, "R10");
        rd(6'h0b, "R10");

        // Constrained random: few tags so lines collide
        for (int n = 0; n < 4000; n++) begin
            logic [AW-1:0] a, sa;
            a  = {TW'($urandom % 3), IW'($urandom % NL)};
            sa = {TW'($urandom % 3), IW'($urandom % NL)};
            step(($urandom % 5) != 0, 2'($urandom % 4), a, DW'($urandom),
                 ($urandom % 3) == 0, 2'($urandom % 4), sa, "RND");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule